// File: doc/BRIEF.md
# Write-Protected GPIO Pin-Function Controller

This block is a memory-mapped controller for a configurable number of 8-pin ports. A simple register bus reaches, for each port, a direction register with a 2-bit code per pin, an output-data register, a read-only input-data register and a mode register. It also reaches one function-select register per pin and a single write-protect register. For every pin the block drives a pad output value, a pad output enable and a peripheral function index. It also samples the pad input level.

A pin in GPIO mode is driven from the output-data register when its direction code says output. A pin in peripheral mode takes its value and enable from the peripheral vectors of the function its function-select register names. Writes to the function-select registers are accepted only after an ordered unlock sequence on the write-protect register. Its bit 7 guards bit 6, and bit 6 opens the function selects to writes. Pin identifier `id` maps to port `id / 8`, bit `id % 8`.

Top module: `gpio_pfc_ctrl`

## Requirements
- R1: After reset every direction field is 2'b00, every mode and output-data bit is 0, every function select is 0 and the write-protect register reads 0x80. All pad output enables and all function indices are 0.
- R2: Byte addresses are fixed as follows. Direction is 16-bit at 0x000+2*port. Output data is at 0x040+port, input data at 0x060+port and mode at 0x080+port. The function select of pin id is at 0x200+id (that is, 0x200+port*8+bit). Write-protect is at 0x2FF. Pin id drives pad bit id.
- R3: A pin's direction code sits at bits [2*bit+1:2*bit] of its port's direction register. Code 2'b11 is output, 2'b10 is input and 2'b00 is unused Hi-Z. In GPIO mode (mode bit 0) the pad output enable is 1 only for code 2'b11, and the pad output value is the pin's output-data bit.
- R4: A halfword access (bus_size_i=1) to a direction register writes all 16 bits. A byte access writes bits [7:0] at the even address or bits [15:8] at the odd address and leaves the other byte unchanged.
- R5: Input data goes through a two-flop synchronizer. A read returns the synchronized level for pins whose direction code is not 2'b00 and returns 0 for unused pins. Writes to input-data addresses have no effect.
- R6: While write-protect bit 7 is 1, a write to the write-protect register updates only bit 7, and bit 6 keeps its value. While bit 7 is 0, both bits take the written value. Bits [5:0] always read 0.
- R7: Writing 0x00 and then 0x40 to write-protect leaves it at 0x40, and function-select writes are then accepted. Writing 0x00 and then 0x80 returns it to 0x80.
- R8: A function-select write while write-protect bit 6 is 0 is ignored, and the register keeps its old value.
- R9: In a function-select register, bits [5:0] are the function number, bit 6 is a stored interrupt-select flag and bit 7 reads 0.
- R10: In peripheral mode (mode bit 1), the pin's function index output is its function number. The pad value and enable come from periph_out_i and periph_oe_i at bit func*NUM_PINS+id, or are 0 when func >= NUM_FUNCS. In GPIO mode the function index output is 0.
- R11: Read data appears on bus_rdata_o in the cycle after the request. Reads of unmapped addresses or absent ports return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 1 | Access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 1 | 0 = byte, 1 = halfword |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 16 | Write data (bytes on [7:0]) |
| bus_rdata_o | output | 16 | Read data, registered |
| pad_in_i | input | NUM_PORTS*8 | Pad input levels |
| pad_out_o | output | NUM_PORTS*8 | Pad output values |
| pad_oe_o | output | NUM_PORTS*8 | Pad output enables |
| pin_func_o | output | NUM_PORTS*8*6 | Per-pin function index, 6 bits each |
| periph_out_i | input | NUM_FUNCS*NUM_PORTS*8 | Peripheral output values, function-major |
| periph_oe_i | input | NUM_FUNCS*NUM_PORTS*8 | Peripheral output enables, function-major |

## Verification
A pad input change and a bus read of the input-data register can fall in the same cycle. The bench changes all pads at the same negative edge where it issues the first of three back-to-back reads of one input-data address. It expects the old value from the first two reads and the new value only from the third, which pins the two synchronizer stages and the registered read data to exact cycles. A second overlap is a write-protect write landing while bit 7 is already set with bit 6 at 1. The bench judges it by reading back that bit 6 survived.

// File: rtl/gpio_pfc_pkg.sv
package gpio_pfc_pkg;

    localparam int PINS_PER_PORT = 8;
    localparam int FUNC_W        = 6;
    localparam int FSEL_W        = 7;

    localparam logic [11:0] BASE_DIR  = 12'h000;
    localparam logic [11:0] BASE_ODR  = 12'h040;
    localparam logic [11:0] BASE_IDR  = 12'h060;
    localparam logic [11:0] BASE_MODE = 12'h080;
    localparam logic [11:0] END_MODE  = 12'h0A0;
    localparam logic [11:0] BASE_FSEL = 12'h200;
    localparam logic [11:0] ADDR_WP   = 12'h2FF;

    typedef enum logic [1:0] {
        DIR_NONUSE = 2'b00,
        DIR_RSVD   = 2'b01,
        DIR_IN     = 2'b10,
        DIR_OUT    = 2'b11
    } dir_code_e;

    typedef enum logic [2:0] {
        RG_NONE, RG_DIR, RG_ODR, RG_IDR, RG_MODE, RG_FSEL, RG_WP
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [4:0] port;
        logic [2:0] bitn;
        logic       hi;
    } decode_t;

    typedef struct packed {
        logic              isel;
        logic [FUNC_W-1:0] func;
    } fsel_t;

    function automatic decode_t decode_addr(input logic [11:0] a, input int nports);
        decode_t d;
        d.region = RG_NONE;
        d.port   = '0;
        d.bitn   = '0;
        d.hi     = 1'b0;
        if (a < BASE_ODR) begin
            d.port = a[5:1];
            d.hi   = a[0];
            if (int'(a[5:1]) < nports) d.region = RG_DIR;
        end else if (a < BASE_IDR) begin
            d.port = a[4:0];
            if (int'(a[4:0]) < nports) d.region = RG_ODR;
        end else if (a < BASE_MODE) begin
            d.port = a[4:0];
            if (int'(a[4:0]) < nports) d.region = RG_IDR;
        end else if (a < END_MODE) begin
            d.port = a[4:0];
            if (int'(a[4:0]) < nports) d.region = RG_MODE;
        end else if (a == ADDR_WP) begin
            d.region = RG_WP;
        end else if (a >= BASE_FSEL && a < ADDR_WP) begin
            d.port = a[7:3];
            d.bitn = a[2:0];
            if (int'(a[7:3]) < nports) d.region = RG_FSEL;
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_pfc_wprot.sv
module gpio_pfc_wprot (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] wp_o,
    output logic       fsel_wr_ok_o
);
    logic lock_q;
    logic en_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lock_q <= 1'b1;
            en_q   <= 1'b0;
        end else if (wr_i) begin
            lock_q <= wdata_i[7];
            if (!lock_q) en_q <= wdata_i[6];
        end
    end

    assign wp_o         = {lock_q, en_q, 6'b0};
    assign fsel_wr_ok_o = en_q;
endmodule

// File: rtl/gpio_pfc_sync.sv
module gpio_pfc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/gpio_pfc_regs.sv
module gpio_pfc_regs
    import gpio_pfc_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        bus_req_i,
    input  logic                        bus_we_i,
    input  logic                        bus_size_i,
    input  logic [11:0]                 bus_addr_i,
    input  logic [15:0]                 bus_wdata_i,
    output logic [15:0]                 bus_rdata_o,
    input  logic                        fsel_wr_ok_i,
    input  logic [7:0]                  wp_i,
    output logic                        wp_wr_o,
    input  logic [NUM_PORTS*8-1:0]      idr_sync_i,
    output logic [NUM_PORTS*16-1:0]     dir_o,
    output logic [NUM_PORTS*8-1:0]      odr_o,
    output logic [NUM_PORTS*8-1:0]      mode_o,
    output logic [NUM_PORTS*8*FSEL_W-1:0] fsel_o
);
    localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int PIN_W    = PORT_W + 3;

    logic [15:0] dir_q  [NUM_PORTS];
    logic [7:0]  odr_q  [NUM_PORTS];
    logic [7:0]  mode_q [NUM_PORTS];
    fsel_t       fsel_q [NUM_PINS];

    decode_t dec;
    logic [PORT_W-1:0] port_idx;
    logic [PIN_W-1:0]  pin_idx;
    logic [4:0]        unused_port_hi;
    logic              wr_en;
    logic              rd_en;
    logic [NUM_PINS-1:0] idr_masked;

    assign dec            = decode_addr(bus_addr_i, NUM_PORTS);
    assign port_idx       = dec.port[PORT_W-1:0];
    assign pin_idx        = {port_idx, dec.bitn};
    assign unused_port_hi = dec.port;
    assign wr_en          = bus_req_i && bus_we_i;
    assign rd_en          = bus_req_i && !bus_we_i;
    assign wp_wr_o        = wr_en && (dec.region == RG_WP);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assign odr_o[p*8 +: 8]   = odr_q[p];
            assign mode_o[p*8 +: 8]  = mode_q[p];
            assign dir_o[p*16 +: 16] = dir_q[p];
        end
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            assign fsel_o[i*FSEL_W +: FSEL_W] = fsel_q[i];
            assign idr_masked[i] = idr_sync_i[i] &&
                (dir_q[i/8][(i%8)*2 +: 2] != DIR_NONUSE);
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                dir_q[p]  <= '0;
                odr_q[p]  <= '0;
                mode_q[p] <= '0;
            end
            for (int i = 0; i < NUM_PINS; i++) fsel_q[i] <= '0;
        end else if (wr_en) begin
            unique case (dec.region)
                RG_DIR: begin
                    if (bus_size_i)  dir_q[port_idx]       <= bus_wdata_i;
                    else if (dec.hi) dir_q[port_idx][15:8] <= bus_wdata_i[7:0];
                    else             dir_q[port_idx][7:0]  <= bus_wdata_i[7:0];
                end
                RG_ODR:  odr_q[port_idx]  <= bus_wdata_i[7:0];
                RG_MODE: mode_q[port_idx] <= bus_wdata_i[7:0];
                RG_FSEL: if (fsel_wr_ok_i) fsel_q[pin_idx] <= fsel_t'(bus_wdata_i[FSEL_W-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bus_rdata_o <= '0;
        end else if (rd_en) begin
            unique case (dec.region)
                RG_DIR: begin
                    if (bus_size_i)  bus_rdata_o <= dir_q[port_idx];
                    else if (dec.hi) bus_rdata_o <= {8'h00, dir_q[port_idx][15:8]};
                    else             bus_rdata_o <= {8'h00, dir_q[port_idx][7:0]};
                end
                RG_ODR:  bus_rdata_o <= {8'h00, odr_q[port_idx]};
                RG_IDR:  bus_rdata_o <= {8'h00, idr_masked[{port_idx, 3'b000} +: 8]};
                RG_MODE: bus_rdata_o <= {8'h00, mode_q[port_idx]};
                RG_FSEL: bus_rdata_o <= {9'h000, fsel_q[pin_idx]};
                RG_WP:   bus_rdata_o <= {8'h00, wp_i};
                default: bus_rdata_o <= '0;
            endcase
        end else begin
            bus_rdata_o <= '0;
        end
    end
endmodule

// File: rtl/gpio_pfc_padmux.sv
module gpio_pfc_padmux
    import gpio_pfc_pkg::*;
#(
    parameter int NUM_PINS  = 32,
    parameter int NUM_FUNCS = 4
) (
    input  logic [NUM_PINS*2-1:0]         dir_i,
    input  logic [NUM_PINS-1:0]           odr_i,
    input  logic [NUM_PINS-1:0]           mode_i,
    input  logic [NUM_PINS*FSEL_W-1:0]    fsel_i,
    input  logic [NUM_FUNCS*NUM_PINS-1:0] periph_out_i,
    input  logic [NUM_FUNCS*NUM_PINS-1:0] periph_oe_i,
    output logic [NUM_PINS-1:0]           pad_out_o,
    output logic [NUM_PINS-1:0]           pad_oe_o,
    output logic [NUM_PINS*FUNC_W-1:0]    pin_func_o
);
    localparam int FI_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            logic [NUM_FUNCS-1:0] fn_out;
            logic [NUM_FUNCS-1:0] fn_oe;
            fsel_t                sel;
            dir_code_e            code;

            for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
                assign fn_out[f] = periph_out_i[f*NUM_PINS + i];
                assign fn_oe[f]  = periph_oe_i[f*NUM_PINS + i];
            end

            assign sel  = fsel_t'(fsel_i[i*FSEL_W +: FSEL_W]);
            assign code = dir_code_e'(dir_i[i*2 +: 2]);

            always_comb begin
                pad_out_o[i]               = 1'b0;
                pad_oe_o[i]                = 1'b0;
                pin_func_o[i*FUNC_W +: FUNC_W] = '0;
                if (mode_i[i]) begin
                    pin_func_o[i*FUNC_W +: FUNC_W] = sel.func;
                    if (int'(sel.func) < NUM_FUNCS) begin
                        pad_out_o[i] = fn_out[sel.func[FI_W-1:0]];
                        pad_oe_o[i]  = fn_oe[sel.func[FI_W-1:0]];
                    end
                end else begin
                    pad_out_o[i] = odr_i[i];
                    pad_oe_o[i]  = (code == DIR_OUT);
                end
            end
        end
    endgenerate

    logic unused_isel;
    always_comb begin
        unused_isel = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) unused_isel ^= fsel_i[i*FSEL_W + FUNC_W];
    end
endmodule

// File: rtl/gpio_pfc_ctrl.sv
module gpio_pfc_ctrl
    import gpio_pfc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_FUNCS = 4
) (
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic                            bus_req_i,
    input  logic                            bus_we_i,
    input  logic                            bus_size_i,
    input  logic [11:0]                     bus_addr_i,
    input  logic [15:0]                     bus_wdata_i,
    output logic [15:0]                     bus_rdata_o,
    input  logic [NUM_PORTS*8-1:0]          pad_in_i,
    output logic [NUM_PORTS*8-1:0]          pad_out_o,
    output logic [NUM_PORTS*8-1:0]          pad_oe_o,
    output logic [NUM_PORTS*8*6-1:0]        pin_func_o,
    input  logic [NUM_FUNCS*NUM_PORTS*8-1:0] periph_out_i,
    input  logic [NUM_FUNCS*NUM_PORTS*8-1:0] periph_oe_i
);
    localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

    logic [7:0]                 wp_q;
    logic                       fsel_wr_ok;
    logic                       wp_wr;
    logic [NUM_PINS-1:0]        pad_sync;
    logic [NUM_PINS*2-1:0]      dir_flat;
    logic [NUM_PINS-1:0]        odr_flat;
    logic [NUM_PINS-1:0]        mode_flat;
    logic [NUM_PINS*FSEL_W-1:0] fsel_flat;

    gpio_pfc_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pad_in_i),
        .q_o   (pad_sync)
    );

    gpio_pfc_wprot u_wprot (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_i         (wp_wr),
        .wdata_i      (bus_wdata_i[7:0]),
        .wp_o         (wp_q),
        .fsel_wr_ok_o (fsel_wr_ok)
    );

    gpio_pfc_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .bus_req_i    (bus_req_i),
        .bus_we_i     (bus_we_i),
        .bus_size_i   (bus_size_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_rdata_o  (bus_rdata_o),
        .fsel_wr_ok_i (fsel_wr_ok),
        .wp_i         (wp_q),
        .wp_wr_o      (wp_wr),
        .idr_sync_i   (pad_sync),
        .dir_o        (dir_flat),
        .odr_o        (odr_flat),
        .mode_o       (mode_flat),
        .fsel_o       (fsel_flat)
    );

    gpio_pfc_padmux #(.NUM_PINS(NUM_PINS), .NUM_FUNCS(NUM_FUNCS)) u_padmux (
        .dir_i        (dir_flat),
        .odr_i        (odr_flat),
        .mode_i       (mode_flat),
        .fsel_i       (fsel_flat),
        .periph_out_i (periph_out_i),
        .periph_oe_i  (periph_oe_i),
        .pad_out_o    (pad_out_o),
        .pad_oe_o     (pad_oe_o),
        .pin_func_o   (pin_func_o)
    );
endmodule

// File: rtl/gpio_pfc_chk.sv
module gpio_pfc_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                      clk_i,
    input logic                      rst_i,
    input logic                      bus_req_i,
    input logic                      bus_we_i,
    input logic [11:0]               bus_addr_i,
    input logic [7:0]                wp_q,
    input logic [NUM_PORTS*8*7-1:0]  fsel_flat,
    input logic [NUM_PORTS*8*2-1:0]  dir_flat,
    input logic [NUM_PORTS*8-1:0]    mode_flat,
    input logic [NUM_PORTS*8-1:0]    pad_oe_o,
    input logic [NUM_PORTS*8*6-1:0]  pin_func_o
);
    localparam int NUM_PINS = NUM_PORTS * 8;

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (wp_q == 8'h80 && pad_oe_o == '0 && pin_func_o == '0));

    // R6
    wp_hold_en_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_req_i && bus_we_i && bus_addr_i == 12'h2FF && wp_q[7])
        |=> (wp_q[6] == $past(wp_q[6])));

    // R8
    fsel_guard_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !wp_q[6] |=> $stable(fsel_flat));

    // R6
    wp_low_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wp_q[5:0] == 6'b0);

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            // R3
            gpio_oe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                (!mode_flat[i] && dir_flat[i*2 +: 2] != 2'b11) |-> !pad_oe_o[i]);
            // R10
            gpio_func_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                !mode_flat[i] |-> (pin_func_o[i*6 +: 6] == 6'd0));
        end
    endgenerate
endmodule

bind gpio_pfc_ctrl gpio_pfc_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .wp_q       (wp_q),
    .fsel_flat  (fsel_flat),
    .dir_flat   (dir_flat),
    .mode_flat  (mode_flat),
    .pad_oe_o   (pad_oe_o),
    .pin_func_o (pin_func_o)
);

// File: tb/gpio_pfc_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_pfc_ctrl_tb_top;
    localparam int NP   = 4;
    localparam int NF   = 4;
    localparam int PINS = NP * 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req = 1'b0;
    logic                 we = 1'b0;
    logic                 size = 1'b0;
    logic [11:0]          addr = '0;
    logic [15:0]          wdata = '0;
    logic [15:0]          rdata;
    logic [PINS-1:0]      pad_in = '0;
    logic [PINS-1:0]      pad_out;
    logic [PINS-1:0]      pad_oe;
    logic [PINS*6-1:0]    pin_func;
    logic [NF*PINS-1:0]   p_out = '0;
    logic [NF*PINS-1:0]   p_oe = '0;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    gpio_pfc_ctrl #(.NUM_PORTS(NP), .NUM_FUNCS(NF)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .bus_req_i    (req),
        .bus_we_i     (we),
        .bus_size_i   (size),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .pad_in_i     (pad_in),
        .pad_out_o    (pad_out),
        .pad_oe_o     (pad_oe),
        .pin_func_o   (pin_func),
        .periph_out_i (p_out),
        .periph_oe_i  (p_oe)
    );

    task automatic check(input string req_tag, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req_tag, what, act, exp);
        end
    endtask

    // called at a negative edge, returns at a negative edge
    task automatic bus_wr(input logic [11:0] a, input logic [15:0] d, input logic half);
        req = 1'b1; we = 1'b1; size = half; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic half, output logic [15:0] d);
        req = 1'b1; we = 1'b0; size = half; addr = a;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1", "pad_oe after reset", int'(pad_oe), 0);
        check("R1", "pin_func after reset", int'(pin_func[31:0]), 0);
        bus_rd(12'h000, 1'b1, d); check("R1", "dir port0", d, 0);
        bus_rd(12'h2FF, 1'b0, d); check("R1", "write-protect", d, 16'h0080);
        bus_rd(12'h083, 1'b0, d); check("R1", "mode port3", d, 0);
        bus_rd(12'h040, 1'b0, d); check("R1", "odr port0", d, 0);
        bus_rd(12'h21F, 1'b0, d); check("R1", "fsel pin31", d, 0);
    endtask

    task automatic t_gpio_dir();
        logic [15:0] d;
        // pin0 output, pin1 input, pin2 unused
        bus_wr(12'h000, 16'h000B, 1'b1);
        bus_wr(12'h040, 16'h0005, 1'b0);
        check("R3", "oe pin0 (code 11)", pad_oe[0], 1);
        check("R3", "oe pin1 (code 10)", pad_oe[1], 0);
        check("R3", "oe pin2 (code 00)", pad_oe[2], 0);
        check("R3", "out pin0 = odr", pad_out[0], 1);
        check("R3", "out pin1 = odr", pad_out[1], 0);
        // R4 byte write to upper byte sets pin7 to output
        bus_wr(12'h001, 16'h00C0, 1'b0);
        bus_rd(12'h000, 1'b1, d); check("R4", "dir after upper byte write", d, 16'hC00B);
        bus_rd(12'h001, 1'b0, d); check("R4", "dir upper byte read", d, 16'h00C0);
        check("R4", "oe pin7", pad_oe[7], 1);
        bus_wr(12'h000, 16'h000F, 1'b0);
        bus_rd(12'h000, 1'b1, d); check("R4", "dir after lower byte write", d, 16'hC00F);
        bus_wr(12'h000, 16'hC00B, 1'b1);
        // R2 port2 direction at 0x004 drives pad 16
        bus_wr(12'h004, 16'h0003, 1'b1);
        check("R2", "oe pad16 via port2 dir", pad_oe[16], 1);
        check("R2", "oe pad8 untouched", pad_oe[8], 0);
        bus_wr(12'h042, 16'h0001, 1'b0);
        check("R2", "out pad16 via port2 odr", pad_out[16], 1);
    endtask

    task automatic t_input_sync();
        logic [15:0] d0, d1, d2, d;
        // port0: pins 0,7 output, pin1 input, others unused -> readable mask 0x83
        pad_in = '0;
        repeat (4) @(negedge clk);
        pad_in = '1;
        bus_rd(12'h060, 1'b0, d0);
        bus_rd(12'h060, 1'b0, d1);
        bus_rd(12'h060, 1'b0, d2);
        check("R5", "idr read 1 (same cycle as pad change)", d0, 0);
        check("R5", "idr read 2 (one stage through)", d1, 0);
        check("R5", "idr read 3 (synced, unused pins 0)", d2, 16'h0083);
        bus_wr(12'h060, 16'h0000, 1'b0);
        bus_rd(12'h060, 1'b0, d); check("R5", "idr write ignored", d, 16'h0083);
        bus_rd(12'h061, 1'b0, d); check("R5", "idr port1 all unused", d, 0);
    endtask

    task automatic t_wprot();
        logic [15:0] d;
        bus_wr(12'h20D, 16'h0002, 1'b0);
        bus_rd(12'h20D, 1'b0, d); check("R8", "fsel write while locked", d, 0);
        bus_wr(12'h2FF, 16'h00C0, 1'b0);
        bus_rd(12'h2FF, 1'b0, d); check("R6", "locked write keeps bit6", d, 16'h0080);
        bus_wr(12'h2FF, 16'h0040, 1'b0);
        bus_rd(12'h2FF, 1'b0, d); check("R6", "locked write changes only bit7", d, 16'h0000);
        bus_wr(12'h2FF, 16'h0040, 1'b0);
        bus_rd(12'h2FF, 1'b0, d); check("R7", "unlocked value", d, 16'h0040);
        bus_wr(12'h20D, 16'h0042, 1'b0);
        bus_rd(12'h20D, 1'b0, d); check("R9", "fsel isel+func stored", d, 16'h0042);
        bus_wr(12'h20C, 16'h00FF, 1'b0);
        bus_rd(12'h20C, 1'b0, d); check("R9", "fsel bit7 reads 0", d, 16'h007F);
        bus_wr(12'h2FF, 16'h00FF, 1'b0);
        bus_rd(12'h2FF, 1'b0, d); check("R6", "bits 5:0 read 0", d, 16'h00C0);
        bus_wr(12'h2FF, 16'h0000, 1'b0);
        bus_rd(12'h2FF, 1'b0, d); check("R6", "bit6 survives write under lock", d, 16'h0040);
        bus_wr(12'h20C, 16'h0000, 1'b0);
        bus_wr(12'h2FF, 16'h0000, 1'b0);
        bus_wr(12'h2FF, 16'h0080, 1'b0);
        bus_rd(12'h2FF, 1'b0, d); check("R7", "relocked value", d, 16'h0080);
        bus_wr(12'h20D, 16'h0001, 1'b0);
        bus_rd(12'h20D, 1'b0, d); check("R8", "fsel write after relock ignored", d, 16'h0042);
    endtask

    task automatic t_periph();
        // pin 13 = port1 bit5, fsel 0x20D holds func 2
        p_out[2*PINS + 13] = 1'b1; p_oe[2*PINS + 13] = 1'b1;
        p_out[1*PINS + 13] = 1'b0; p_oe[1*PINS + 13] = 1'b1;
        bus_wr(12'h081, 16'h0020, 1'b0);
        check("R10", "func index pin13", int'(pin_func[13*6 +: 6]), 2);
        check("R10", "out pin13 from func2", pad_out[13], 1);
        check("R10", "oe pin13 from func2 (dir unused)", pad_oe[13], 1);
        check("R2", "pin12 stays GPIO", int'(pin_func[12*6 +: 6]), 0);
        bus_wr(12'h2FF, 16'h0000, 1'b0);
        bus_wr(12'h2FF, 16'h0040, 1'b0);
        bus_wr(12'h20D, 16'h0005, 1'b0);
        check("R10", "func index 5", int'(pin_func[13*6 +: 6]), 5);
        check("R10", "oe off for absent func", pad_oe[13], 0);
        check("R10", "out off for absent func", pad_out[13], 0);
        bus_wr(12'h20D, 16'h0001, 1'b0);
        check("R10", "oe from func1", pad_oe[13], 1);
        check("R10", "out from func1", pad_out[13], 0);
        bus_wr(12'h081, 16'h0000, 1'b0);
        check("R10", "GPIO mode func index 0", int'(pin_func[13*6 +: 6]), 0);
        check("R3", "GPIO mode unused pin oe", pad_oe[13], 0);
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        bus_rd(12'h300, 1'b0, d); check("R11", "unmapped read", d, 0);
        bus_rd(12'h008, 1'b1, d); check("R11", "absent port dir read", d, 0);
        bus_wr(12'h084, 16'h00FF, 1'b0);
        bus_rd(12'h084, 1'b0, d); check("R11", "absent port mode read", d, 0);
        bus_rd(12'h080, 1'b0, d); check("R11", "port0 mode untouched", d, 0);
        check("R11", "no pin entered peripheral mode", int'(pin_func[31:0]), 0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gpio_dir();
        t_input_sync();
        t_wprot();
        t_periph();
        t_unmapped();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end
endmodule